// File: doc/BRIEF.md
# Plug-and-Play Logical Device Configuration Block

This block stores the configuration state of one logical device that sits on a legacy ISA-style bus. Software reaches it through an 8-bit register index and an 8-bit data port, with separate write and read strobes. The block holds the following state:

- an activation flag;
- an I/O range-check control;
- a 16-bit I/O base address;
- two memory descriptors, one for a boot ROM window and one for a shared SRAM window.

The programmed values are presented on output ports for the device's own function logic.

The block also watches I/O read cycles on the bus. While the device is inactive and range checking is enabled, any I/O read that falls in the 32-byte window starting at the programmed base is answered with a fixed test byte. The test byte is 0x55 or 0xAA, selected by a control bit. Configuration software uses this to find conflicts before it activates the device. Outside range checking, the block never drives the data bus.

Top module: `pnp_cfg_regs`

## Requirements
- R1: After synchronous reset, every register reads zero. `dev_active` is 0, `io_base` is 0, every memory output is 0, `bus_doe` is 0 and `bus_dout` is 0.
- R2: Index 0x30 is the activate register. Bit 0 is stored and appears on `dev_active`. Bits 7:1 ignore writes and read 0.
- R3: Index 0x31 is the range-check register. Bit 1 enables range check and bit 0 selects the pattern. Bits 7:2 ignore writes and read 0.
- R4: Index 0x60 holds I/O base bits 15:8 and index 0x61 holds bits 7:0. Both are fully read/write, and `io_base` is {0x60, 0x61}.
- R5: Memory descriptor 0 occupies indices 0x40 to 0x44, in this order: base bits 23:16, base bits 15:8, control, limit/length bits 23:16, limit/length bits 15:8. `mem_base[15:0]` is {0x40, 0x41}, `mem_limit[15:0]` is {0x43, 0x44}, and `mem_wide[0]` is control bit 1. In the control register, bit 1 selects 16-bit access, bit 0 always reads 0 (range-length mode), and bits 7:2 ignore writes and read 0.
- R6: Memory descriptor 1 uses indices 0x48 to 0x4C with the same layout as descriptor 0. It drives `mem_base[31:16]`, `mem_limit[31:16]` and `mem_wide[1]`.
- R7: Every other index reads 0, and writes to it change no register or output.
- R8: A read strobe samples the register at the current index. The value appears on `cfg_rdata` one clock later and holds until the next read strobe. If a read and a write to the same index happen in the same cycle, the read returns the old value.
- R9: Range check is in effect when activate bit 0 is 0 and range-check bit 1 is 1. In that state, an I/O read strobe at an address whose offset (address minus base, modulo 2^16) is 0 to 31 causes `bus_doe` to be 1 one clock later. In that same cycle `bus_dout` is 0x55 if range-check bit 0 is 1, and 0xAA if it is 0.
- R10: In every other case `bus_doe` is 0 and `bus_dout` is 0 one clock later. This covers a device that is active, range check disabled, no read strobe, or an address offset of 32 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_rdata | output | 8 | Registered configuration read data |
| bus_addr | input | 16 | Bus I/O address |
| bus_ior | input | 1 | Bus I/O read strobe |
| bus_dout | output | 8 | Range-check response byte |
| bus_doe | output | 1 | Data bus drive enable |
| dev_active | output | 1 | Device activated |
| io_base | output | 16 | Programmed I/O base address |
| mem_base | output | 2*16 | Memory base bits 23:8, per descriptor |
| mem_limit | output | 2*16 | Memory limit/length bits 23:8, per descriptor |
| mem_wide | output | 2 | 16-bit access select, per descriptor |

## Verification
The hardest case to reach from the ports is a range-check answer at the exact edges of the 32-byte window. The interesting addresses are base+31, which must answer, and base+32 and base-1, which must not. This must also hold when the window wraps past address 0xFFFF, and with both pattern settings. Getting there takes a sequence: the base is programmed through two indices, the device is left inactive, range check is enabled, and the edge addresses are then strobed. The same sweep is repeated with the device active, to show that activation silences the responder. A long random phase then mixes configuration traffic with bus reads near the base, so the reference model sees the state change while reads are in flight.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  localparam logic [7:0] IDX_ACTIVATE  = 8'h30;
  localparam logic [7:0] IDX_RCHK      = 8'h31;
  localparam logic [7:0] IDX_IO_HI     = 8'h60;
  localparam logic [7:0] IDX_IO_LO     = 8'h61;
  localparam logic [7:0] IDX_MEM_FIRST = 8'h40;
  localparam int         MEM_STRIDE    = 8;
  localparam logic [7:0] PAT_SET       = 8'h55;
  localparam logic [7:0] PAT_CLR       = 8'hAA;

  typedef struct packed {
    logic [7:0] base_hi;
    logic [7:0] base_lo;
    logic [7:0] lim_hi;
    logic [7:0] lim_lo;
    logic       w16;
  } mem_desc_t;
endpackage

// File: rtl/pnp_mem_desc.sv
module pnp_mem_desc
  import pnp_cfg_pkg::*;
#(
  parameter logic [7:0] IDX_BASE = 8'h40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_idx,
  input  logic [7:0] cfg_wdata,
  output logic       sel,
  output logic [7:0] rd_byte,
  output mem_desc_t  desc
);
  // Five registers at offsets 0..4 inside an 8-aligned group
  assign sel = (cfg_idx[7:3] == IDX_BASE[7:3]) && (cfg_idx[2:0] <= 3'd4);

  always_ff @(posedge clk) begin
    if (rst) begin
      desc <= '0;
    end else if (cfg_wr && sel) begin
      case (cfg_idx[2:0])
        3'd0:    desc.base_hi <= cfg_wdata;
        3'd1:    desc.base_lo <= cfg_wdata;
        3'd2:    desc.w16     <= cfg_wdata[1];
        3'd3:    desc.lim_hi  <= cfg_wdata;
        3'd4:    desc.lim_lo  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    case (cfg_idx[2:0])
      3'd0:    rd_byte = desc.base_hi;
      3'd1:    rd_byte = desc.base_lo;
      3'd2:    rd_byte = {6'b0, desc.w16, 1'b0};
      3'd3:    rd_byte = desc.lim_hi;
      3'd4:    rd_byte = desc.lim_lo;
      default: rd_byte = 8'h00;
    endcase
  end

  // R5: a control write lands in the width select on the next cycle
  a_r5_w16_write: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && sel && cfg_idx[2:0] == 3'd2) |=> (desc.w16 == $past(cfg_wdata[1])));
endmodule

// File: rtl/pnp_range_resp.sv
module pnp_range_resp
  import pnp_cfg_pkg::*;
#(
  parameter int IO_DEC_BITS = 16,
  parameter int WIN_BITS    = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        pat_sel,
  input  logic [15:0] io_base,
  input  logic [15:0] bus_addr,
  input  logic        bus_ior,
  output logic        bus_doe,
  output logic [7:0]  bus_dout
);
  logic [IO_DEC_BITS-1:0] off;
  logic                   hit;

  assign off = bus_addr[IO_DEC_BITS-1:0] - io_base[IO_DEC_BITS-1:0];
  assign hit = (off >> WIN_BITS) == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_doe  <= 1'b0;
      bus_dout <= 8'h00;
    end else if (bus_ior && hit && enable) begin
      bus_doe  <= 1'b1;
      bus_dout <= pat_sel ? PAT_SET : PAT_CLR;
    end else begin
      bus_doe  <= 1'b0;
      bus_dout <= 8'h00;
    end
  end

  a_r10_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> $past(bus_ior));
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !bus_doe);
  a_r9_pattern_legal: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> (bus_dout == PAT_SET || bus_dout == PAT_CLR));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_doe |-> (bus_dout == 8'h00));
endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
  import pnp_cfg_pkg::*;
#(
  parameter int IO_DEC_BITS = 16,
  parameter int WIN_BITS    = 5,
  parameter int N_MEM       = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          cfg_idx,
  input  logic [7:0]          cfg_wdata,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  output logic [7:0]          cfg_rdata,
  input  logic [15:0]         bus_addr,
  input  logic                bus_ior,
  output logic [7:0]          bus_dout,
  output logic                bus_doe,
  output logic                dev_active,
  output logic [15:0]         io_base,
  output logic [N_MEM*16-1:0] mem_base,
  output logic [N_MEM*16-1:0] mem_limit,
  output logic [N_MEM-1:0]    mem_wide
);
  localparam logic [15:0] IO_MASK = 16'((32'd1 << IO_DEC_BITS) - 32'd1);

  logic       act_q;
  logic [1:0] rchk_q;
  logic [7:0] io_hi_q, io_lo_q;
  logic [7:0] rd_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      rchk_q  <= 2'b00;
      io_hi_q <= 8'h00;
      io_lo_q <= 8'h00;
    end else if (cfg_wr) begin
      case (cfg_idx)
        IDX_ACTIVATE: act_q   <= cfg_wdata[0];
        IDX_RCHK:     rchk_q  <= cfg_wdata[1:0];
        IDX_IO_HI:    io_hi_q <= cfg_wdata & IO_MASK[15:8];
        IDX_IO_LO:    io_lo_q <= cfg_wdata & IO_MASK[7:0];
        default: ;
      endcase
    end
  end

  mem_desc_t        desc [N_MEM];
  logic [N_MEM-1:0] dsel;
  logic [7:0]       drd  [N_MEM];

  for (genvar g = 0; g < N_MEM; g++) begin : g_desc
    pnp_mem_desc #(
      .IDX_BASE(8'(int'(IDX_MEM_FIRST) + g * MEM_STRIDE))
    ) u_desc (
      .clk      (clk),
      .rst      (rst),
      .cfg_wr   (cfg_wr),
      .cfg_idx  (cfg_idx),
      .cfg_wdata(cfg_wdata),
      .sel      (dsel[g]),
      .rd_byte  (drd[g]),
      .desc     (desc[g])
    );
    assign mem_base[g*16 +: 16]  = {desc[g].base_hi, desc[g].base_lo};
    assign mem_limit[g*16 +: 16] = {desc[g].lim_hi, desc[g].lim_lo};
    assign mem_wide[g]           = desc[g].w16;
  end

  always_comb begin
    case (cfg_idx)
      IDX_ACTIVATE: rd_val = {7'b0, act_q};
      IDX_RCHK:     rd_val = {6'b0, rchk_q};
      IDX_IO_HI:    rd_val = io_hi_q;
      IDX_IO_LO:    rd_val = io_lo_q;
      default:      rd_val = 8'h00;
    endcase
    for (int k = 0; k < N_MEM; k++) begin
      if (dsel[k]) rd_val = drd[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= 8'h00;
    else if (cfg_rd) cfg_rdata <= rd_val;
  end

  pnp_range_resp #(
    .IO_DEC_BITS(IO_DEC_BITS),
    .WIN_BITS   (WIN_BITS)
  ) u_resp (
    .clk     (clk),
    .rst     (rst),
    .enable  (!act_q && rchk_q[1]),
    .pat_sel (rchk_q[0]),
    .io_base ({io_hi_q, io_lo_q}),
    .bus_addr(bus_addr),
    .bus_ior (bus_ior),
    .bus_doe (bus_doe),
    .bus_dout(bus_dout)
  );

  assign dev_active = act_q;
  assign io_base    = {io_hi_q, io_lo_q};

  a_r2_rise_by_write: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_active) |-> $past(cfg_wr && cfg_idx == IDX_ACTIVATE && cfg_wdata[0]));
  a_r2_act_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_idx == IDX_ACTIVATE) |=> (cfg_rdata[7:1] == 7'd0));
  a_r3_rchk_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_idx == IDX_RCHK) |=> (cfg_rdata[7:2] == 6'd0));
  a_r5_ctrl_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_idx[7:6] == 2'b01 && cfg_idx[2:0] == 3'd2) |=> ((cfg_rdata & 8'hFD) == 8'h00));
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_rd) |-> $stable(cfg_rdata));
  a_r10_active_silent: assert property (@(posedge clk) disable iff (rst)
    dev_active |=> !bus_doe);
endmodule

// File: tb/sim_pnp_cfg_regs.sv
module sim_pnp_cfg_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_idx = 8'h00, cfg_wdata = 8'h00;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_ior = 1'b0;
  logic [7:0]  cfg_rdata, bus_dout;
  logic        bus_doe, dev_active;
  logic [15:0] io_base;
  logic [31:0] mem_base, mem_limit;
  logic [1:0]  mem_wide;

  always #2 clk = ~clk;

  pnp_cfg_regs u0 (
    .clk(clk), .rst(rst), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
    .bus_addr(bus_addr), .bus_ior(bus_ior), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .dev_active(dev_active), .io_base(io_base), .mem_base(mem_base),
    .mem_limit(mem_limit), .mem_wide(mem_wide)
  );

  int vectors = 0, errors = 0, cycles = 0;
  bit started = 0;

  logic [7:0] mdl [256];
  logic [7:0] e_rdata = 8'h00, e_dout = 8'h00;
  logic       e_doe = 1'b0;

  function automatic logic [7:0] wmask(input logic [7:0] i);
    if (i == 8'h30) return 8'h01;
    if (i == 8'h31) return 8'h03;
    if (i == 8'h60 || i == 8'h61) return 8'hFF;
    if ((i[7:3] == 5'h08 || i[7:3] == 5'h09) && i[2:0] <= 3'd4)
      return (i[2:0] == 3'd2) ? 8'h02 : 8'hFF;
    return 8'h00;
  endfunction

  function automatic string req_of(input logic [7:0] i);
    if (i == 8'h30) return "R2";
    if (i == 8'h31) return "R3";
    if (i == 8'h60 || i == 8'h61) return "R4";
    if (i[7:3] == 5'h08 && i[2:0] <= 3'd4) return "R5";
    if (i[7:3] == 5'h09 && i[2:0] <= 3'd4) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Behavioural reference: register file as a byte array with write masks
  logic [7:8] unused_dummy;
  always @(posedge clk) begin
    int off;
    logic [15:0] b;
    started = 1;
    if (rst) begin
      for (int k = 0; k < 256; k++) mdl[k] = 8'h00;
      e_rdata = 8'h00; e_doe = 1'b0; e_dout = 8'h00;
    end else begin
      if (cfg_rd) e_rdata = mdl[cfg_idx];
      b   = {mdl[8'h60], mdl[8'h61]};
      off = (int'(bus_addr) - int'(b)) & 32'hFFFF;
      if (bus_ior && !mdl[8'h30][0] && mdl[8'h31][1] && off < 32) begin
        e_doe = 1'b1; e_dout = mdl[8'h31][0] ? 8'h55 : 8'hAA;
      end else begin
        e_doe = 1'b0; e_dout = 8'h00;
      end
      if (cfg_wr) mdl[cfg_idx] = cfg_wdata & wmask(cfg_idx);
    end
  end

  logic [7:0] last_rd_idx = 8'h00;
  always @(posedge clk) if (cfg_rd) last_rd_idx <= cfg_idx;

  always @(negedge clk) begin
    cycles++;
    if (started) begin
      chk(req_of(last_rd_idx), "cfg_rdata", {24'b0, cfg_rdata}, {24'b0, e_rdata});
      chk(e_doe ? "R9" : "R10", "bus_doe", {31'b0, bus_doe}, {31'b0, e_doe});
      chk(e_doe ? "R9" : "R10", "bus_dout", {24'b0, bus_dout}, {24'b0, e_dout});
      chk("R2", "dev_active", {31'b0, dev_active}, {31'b0, mdl[8'h30][0]});
      chk("R4", "io_base", {16'b0, io_base}, {16'b0, mdl[8'h60], mdl[8'h61]});
      chk("R5", "mem_base0", {16'b0, mem_base[15:0]}, {16'b0, mdl[8'h40], mdl[8'h41]});
      chk("R5", "mem_limit0", {16'b0, mem_limit[15:0]}, {16'b0, mdl[8'h43], mdl[8'h44]});
      chk("R5", "mem_wide0", {31'b0, mem_wide[0]}, {31'b0, mdl[8'h42][1]});
      chk("R6", "mem_base1", {16'b0, mem_base[31:16]}, {16'b0, mdl[8'h48], mdl[8'h49]});
      chk("R6", "mem_limit1", {16'b0, mem_limit[31:16]}, {16'b0, mdl[8'h4B], mdl[8'h4C]});
      chk("R6", "mem_wide1", {31'b0, mem_wide[1]}, {31'b0, mdl[8'h4A][1]});
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk);
    cfg_wr = 0; cfg_rd = 0; bus_ior = 0;
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk);
    cfg_idx = i; cfg_wdata = d; cfg_wr = 1; cfg_rd = 0; bus_ior = 0;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] i);
    @(negedge clk);
    cfg_idx = i; cfg_rd = 1; cfg_wr = 0; bus_ior = 0;
    @(negedge clk);
    cfg_rd = 0;
  endtask

  task automatic ior(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_ior = 1; cfg_wr = 0; cfg_rd = 0;
    @(negedge clk);
    bus_ior = 0;
  endtask

  task automatic sweep(input logic [15:0] base);
    ior(base - 16'd1); ior(base); ior(base + 16'd17); ior(base + 16'd31); ior(base + 16'd32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "dev_active", {31'b0, dev_active}, 0);
    chk("R1", "bus_doe", {31'b0, bus_doe}, 0);
    chk("R1", "io_base", {16'b0, io_base}, 0);
    chk("R1", "mem_base", mem_base, 0);
    for (int i = 0; i < 256; i++) rd(8'(i));
    // R2 R3 R5 R6 R7: all-ones everywhere then read back masked values
    for (int i = 0; i < 256; i++) wr(8'(i), 8'hFF);
    for (int i = 0; i < 256; i++) rd(8'(i));
    for (int i = 0; i < 256; i++) wr(8'(i), 8'h00);
    for (int i = 0; i < 256; i++) rd(8'(i));
    wr(8'h40, 8'h0C); wr(8'h41, 8'h80); wr(8'h42, 8'hFE); wr(8'h43, 8'h00); wr(8'h44, 8'h40);
    wr(8'h48, 8'h0D); wr(8'h49, 8'h00); wr(8'h4A, 8'h03); wr(8'h4B, 8'h00); wr(8'h4C, 8'h40);
    rd(8'h42); rd(8'h4A);
    // R8: same-cycle read and write returns the old value, then holds
    wr(8'h61, 8'h5A);
    @(negedge clk);
    cfg_idx = 8'h61; cfg_wdata = 8'h33; cfg_wr = 1; cfg_rd = 1;
    @(negedge clk);
    cfg_wr = 0; cfg_rd = 0;
    chk("R8", "old value on collision", {24'b0, cfg_rdata}, 32'h5A);
    idle(); idle();
    chk("R8", "hold", {24'b0, cfg_rdata}, 32'h5A);
    // R9/R10: range check at window edges, both patterns
    wr(8'h60, 8'h03); wr(8'h61, 8'h00);
    wr(8'h31, 8'h03); sweep(16'h0300);
    wr(8'h31, 8'h02); sweep(16'h0300);
    wr(8'h30, 8'h01); sweep(16'h0300);
    wr(8'h30, 8'h00); wr(8'h31, 8'h01); sweep(16'h0300);
    // window that wraps past 0xFFFF
    wr(8'h60, 8'hFF); wr(8'h61, 8'hF0); wr(8'h31, 8'h03);
    sweep(16'hFFF0); ior(16'h000F); ior(16'h0010);
    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      case ($urandom_range(0, 7))
        0: cfg_idx = 8'h30;
        1: cfg_idx = 8'h31;
        2: cfg_idx = 8'h60 + 8'($urandom_range(0, 1));
        3: cfg_idx = 8'h40 + 8'($urandom_range(0, 12));
        default: cfg_idx = 8'($urandom_range(0, 255));
      endcase
      cfg_wdata = 8'($urandom);
      cfg_wr    = ($urandom_range(0, 3) == 0);
      cfg_rd    = ($urandom_range(0, 1) == 0);
      bus_ior   = ($urandom_range(0, 1) == 0);
      bus_addr  = io_base + 16'($urandom_range(0, 40)) - 16'd4;
    end
    idle(); idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule